// File: doc/BRIEF.md
# Page Buffer Read Cursor

This block keeps the read position inside a page buffer of 16-bit halfwords. The buffer holds a main area and, at a configurable offset, a spare area. A host issues flash commands through a strobe. The block sets the read position from the command code and passes the command on, one cycle later, in the form the flash device expects. Two read variants are translated into a plain page read.

After a command, the host pulls data one item at a time with a request strobe. In halfword mode each request returns a whole 16-bit word. In byte mode the two bytes of each halfword come out in turn, low byte first. The block reads the buffer through a synchronous port with one cycle of latency. It returns each item with a valid pulse. A request made after the position has passed the last buffer halfword returns zero and raises an overrun pulse.

Top module: `pbuf_read_cursor`

## Requirements
- R1: A command with code 0x50 (spare read) places the cursor at halfword address SPARE_BASE.
- R2: A command with code 0x01 (second-half read) places the cursor at halfword address PAGE_BYTES/4, which is half a page beyond the main area start at address 0.
- R3: A command with any other code places the cursor at halfword address 0.
- R4: One cycle after `cmdValid`, `cmdFwdValid` is high for one cycle. `cmdFwdCode` is 0x00 when the command was 0x50 or 0x01, and the command code unchanged otherwise.
- R5: Every command sets the byte phase to low, so the next byte-mode read returns a low byte.
- R6: In byte mode (`wideMode`=0), a read in the low phase returns bits 7:0 of the halfword at the cursor in `dataOut[7:0]`, with the upper bits zero, and leaves the cursor unchanged. A read in the high phase returns bits 15:8 in `dataOut[7:0]` and advances the cursor by one.
- R7: In halfword mode (`wideMode`=1), each read returns all 16 bits of the halfword at the cursor, advances the cursor by one and sets the byte phase to low.
- R8: A request made while the cursor is beyond SPARE_BASE + SPARE_BYTES/2 − 1 issues no buffer read. One cycle later it gives `dataValid`=1, `dataOut`=0 and `overrun`=1, sets the byte phase to low and leaves the cursor unchanged.
- R9: A request made while the cursor is in range raises `bufRdEn` in the same cycle, with `bufRdAddr` equal to the cursor. `dataValid` and the data follow exactly one cycle later.
- R10: Synchronous reset sets the cursor to 0 and the byte phase to low, and clears `dataValid`, `overrun` and `cmdFwdValid`.
- R11: When `cmdValid` and `nextReq` are high in the same cycle, the command takes effect and the request is dropped: no buffer read and no `dataValid` follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | Command issued strobe |
| cmdCode | input | 8 | Command code |
| nextReq | input | 1 | Request for the next data item |
| wideMode | input | 1 | 1 = halfword items, 0 = byte items |
| bufRdData | input | 16 | Buffer read data, one cycle after `bufRdEn` |
| cmdFwdValid | output | 1 | Forwarded command strobe |
| cmdFwdCode | output | 8 | Forwarded (translated) command code |
| bufRdEn | output | 1 | Buffer read enable |
| bufRdAddr | output | ADDR_W | Buffer halfword address |
| dataValid | output | 1 | Data item valid |
| dataOut | output | 16 | Data item (byte items in bits 7:0) |
| overrun | output | 1 | The request went past the end of the buffer |

## Verification
The assertions take for granted that reset is held for at least one clock edge before any command or request. They also take for granted that the buffer answers with the word for the address presented in the previous cycle, and the bench's buffer model does exactly that. The bench raises each strobe for a single cycle only and holds `wideMode` steady during a request. It drives the cursor past the end of the buffer only through the spare read and a complete walk of the spare area. Every command and request therefore stays within the input patterns the properties describe.

// File: rtl/pbuf_cursor_pkg.sv
package pbuf_cursor_pkg;

  localparam logic [7:0] CMD_PAGE_READ  = 8'h00;
  localparam logic [7:0] CMD_READ_HALF  = 8'h01;
  localparam logic [7:0] CMD_READ_SPARE = 8'h50;

  typedef enum logic [1:0] {
    START_MAIN  = 2'd0,
    START_HALF  = 2'd1,
    START_SPARE = 2'd2
  } startSel_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic      loadCursor;
    startSel_e startSel;
    logic      stepCursor;
    logic      phaseSet;
    logic      phaseClr;
    logic      fetch;
    logic      retErr;
    logic      retHigh;
    logic      retWide;
  } cursorStrb_t;

endpackage

// File: rtl/pbuf_cursor_ctrl.sv
module pbuf_cursor_ctrl
  import pbuf_cursor_pkg::*;
(
  input  logic        cmdValid,
  input  logic [7:0]  cmdCode,
  input  logic        nextReq,
  input  logic        wideMode,
  input  logic        pastEnd,
  input  logic        phaseHigh,
  output cursorStrb_t strb,
  output logic [7:0]  fwdCode
);

  always_comb begin
    strb = '0;
    strb.startSel = START_MAIN;
    fwdCode = cmdCode;
    if (cmdValid) begin
      strb.loadCursor = 1'b1;
      strb.phaseClr   = 1'b1;
      unique case (cmdCode)
        CMD_READ_SPARE: begin
          strb.startSel = START_SPARE;
          fwdCode = CMD_PAGE_READ;
        end
        CMD_READ_HALF: begin
          strb.startSel = START_HALF;
          fwdCode = CMD_PAGE_READ;
        end
        default: strb.startSel = START_MAIN;
      endcase
    end else if (nextReq) begin
      if (pastEnd) begin
        strb.retErr   = 1'b1;
        strb.phaseClr = 1'b1;
      end else begin
        strb.fetch = 1'b1;
        if (wideMode) begin
          strb.retWide    = 1'b1;
          strb.stepCursor = 1'b1;
          strb.phaseClr   = 1'b1;
        end else if (phaseHigh) begin
          strb.retHigh    = 1'b1;
          strb.stepCursor = 1'b1;
          strb.phaseClr   = 1'b1;
        end else begin
          strb.phaseSet = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pbuf_cursor_dp.sv
module pbuf_cursor_dp
  import pbuf_cursor_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int HALF_OFF   = 128,
  parameter int SPARE_BASE = 256,
  parameter int LAST_ADDR  = 263
) (
  input  logic              clk,
  input  logic              rst,
  input  cursorStrb_t       strb,
  input  logic [7:0]        fwdCode,
  input  logic [15:0]       bufRdData,
  output logic              pastEnd,
  output logic              phaseHigh,
  output logic [ADDR_W-1:0] cursor,
  output logic              cmdFwdValid,
  output logic [7:0]        cmdFwdCode,
  output logic              bufRdEn,
  output logic [ADDR_W-1:0] bufRdAddr,
  output logic              dataValid,
  output logic [15:0]       dataOut,
  output logic              overrun
);

  localparam logic [ADDR_W-1:0] HALF_ADDR  = ADDR_W'(HALF_OFF);
  localparam logic [ADDR_W-1:0] SPARE_ADDR = ADDR_W'(SPARE_BASE);
  localparam logic [ADDR_W-1:0] LAST       = ADDR_W'(LAST_ADDR);

  logic [ADDR_W-1:0] startVal;
  logic rspValid, rspErr, rspHigh, rspWide;

  always_comb begin
    unique case (strb.startSel)
      START_HALF:  startVal = HALF_ADDR;
      START_SPARE: startVal = SPARE_ADDR;
      default:     startVal = '0;
    endcase
  end

  assign pastEnd   = (cursor > LAST);
  assign bufRdEn   = strb.fetch;
  assign bufRdAddr = cursor;

  always_ff @(posedge clk) begin
    if (rst) begin
      cursor      <= '0;
      phaseHigh   <= 1'b0;
      cmdFwdValid <= 1'b0;
      cmdFwdCode  <= '0;
      rspValid    <= 1'b0;
      rspErr      <= 1'b0;
      rspHigh     <= 1'b0;
      rspWide     <= 1'b0;
    end else begin
      cmdFwdValid <= strb.loadCursor;
      if (strb.loadCursor) cmdFwdCode <= fwdCode;
      if (strb.loadCursor)      cursor <= startVal;
      else if (strb.stepCursor) cursor <= cursor + 1'b1;
      if (strb.phaseClr)      phaseHigh <= 1'b0;
      else if (strb.phaseSet) phaseHigh <= 1'b1;
      rspValid <= strb.fetch | strb.retErr;
      rspErr   <= strb.retErr;
      rspHigh  <= strb.retHigh;
      rspWide  <= strb.retWide;
    end
  end

  always_comb begin
    if (!rspValid || rspErr) dataOut = '0;
    else if (rspWide)        dataOut = bufRdData;
    else if (rspHigh)        dataOut = {8'h00, bufRdData[15:8]};
    else                     dataOut = {8'h00, bufRdData[7:0]};
  end

  assign dataValid = rspValid;
  assign overrun   = rspValid & rspErr;

endmodule

// File: rtl/pbuf_read_cursor.sv
module pbuf_read_cursor
  import pbuf_cursor_pkg::*;
#(
  parameter int PAGE_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int SPARE_BASE  = PAGE_BYTES / 2,
  localparam int HALF_OFF   = PAGE_BYTES / 4,
  localparam int LAST_ADDR  = SPARE_BASE + SPARE_BYTES / 2 - 1,
  localparam int ADDR_W     = $clog2(LAST_ADDR + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdValid,
  input  logic [7:0]        cmdCode,
  input  logic              nextReq,
  input  logic              wideMode,
  input  logic [15:0]       bufRdData,
  output logic              cmdFwdValid,
  output logic [7:0]        cmdFwdCode,
  output logic              bufRdEn,
  output logic [ADDR_W-1:0] bufRdAddr,
  output logic              dataValid,
  output logic [15:0]       dataOut,
  output logic              overrun
);

  cursorStrb_t       strb;
  logic [7:0]        fwdCode;
  logic              pastEnd;
  logic              phaseNow;
  logic [ADDR_W-1:0] cursorNow;

  pbuf_cursor_ctrl u_ctrl (
    .cmdValid (cmdValid),
    .cmdCode  (cmdCode),
    .nextReq  (nextReq),
    .wideMode (wideMode),
    .pastEnd  (pastEnd),
    .phaseHigh(phaseNow),
    .strb     (strb),
    .fwdCode  (fwdCode)
  );

  pbuf_cursor_dp #(
    .ADDR_W    (ADDR_W),
    .HALF_OFF  (HALF_OFF),
    .SPARE_BASE(SPARE_BASE),
    .LAST_ADDR (LAST_ADDR)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .fwdCode    (fwdCode),
    .bufRdData  (bufRdData),
    .pastEnd    (pastEnd),
    .phaseHigh  (phaseNow),
    .cursor     (cursorNow),
    .cmdFwdValid(cmdFwdValid),
    .cmdFwdCode (cmdFwdCode),
    .bufRdEn    (bufRdEn),
    .bufRdAddr  (bufRdAddr),
    .dataValid  (dataValid),
    .dataOut    (dataOut),
    .overrun    (overrun)
  );

endmodule

// File: rtl/pbuf_read_cursor_chk.sv
module pbuf_read_cursor_chk #(
  parameter int ADDR_W     = 9,
  parameter int HALF_OFF   = 128,
  parameter int SPARE_BASE = 256,
  parameter int LAST_ADDR  = 263
) (
  input logic              clk,
  input logic              rst,
  input logic              cmdValid,
  input logic [7:0]        cmdCode,
  input logic              nextReq,
  input logic              wideMode,
  input logic              cmdFwdValid,
  input logic [7:0]        cmdFwdCode,
  input logic              bufRdEn,
  input logic [ADDR_W-1:0] bufRdAddr,
  input logic              dataValid,
  input logic [15:0]       dataOut,
  input logic              overrun,
  input logic [ADDR_W-1:0] cursorNow,
  input logic              phaseNow
);

  logic inRange;
  assign inRange = (int'(cursorNow) <= LAST_ADDR);

  p_spare_start_r1: assert property (@(posedge clk) disable iff (rst)
    cmdValid && cmdCode == 8'h50 |=> int'(cursorNow) == SPARE_BASE);

  p_half_start_r2: assert property (@(posedge clk) disable iff (rst)
    cmdValid && cmdCode == 8'h01 |=> int'(cursorNow) == HALF_OFF);

  p_main_start_r3: assert property (@(posedge clk) disable iff (rst)
    cmdValid && cmdCode != 8'h50 && cmdCode != 8'h01 |=> cursorNow == '0);

  p_fwd_code_r4: assert property (@(posedge clk) disable iff (rst)
    cmdValid |=> cmdFwdValid && cmdFwdCode ==
      (($past(cmdCode) == 8'h50 || $past(cmdCode) == 8'h01) ? 8'h00 : $past(cmdCode)));

  p_cmd_phase_r5: assert property (@(posedge clk) disable iff (rst)
    cmdValid |=> !phaseNow);

  p_byte_hold_r6: assert property (@(posedge clk) disable iff (rst)
    nextReq && !cmdValid && !wideMode && !phaseNow && inRange
    |=> phaseNow && cursorNow == $past(cursorNow));

  p_wide_step_r7: assert property (@(posedge clk) disable iff (rst)
    nextReq && !cmdValid && wideMode && inRange
    |=> cursorNow == $past(cursorNow) + 1'b1 && !phaseNow);

  p_overrun_zero_r8: assert property (@(posedge clk) disable iff (rst)
    nextReq && !cmdValid && !inRange
    |-> !bufRdEn ##1 (overrun && dataValid && dataOut == 16'h0 && !phaseNow));

  p_fetch_addr_r9: assert property (@(posedge clk) disable iff (rst)
    nextReq && !cmdValid && inRange |-> bufRdEn && bufRdAddr == cursorNow);

  p_latency_r9: assert property (@(posedge clk) disable iff (rst)
    nextReq && !cmdValid |=> dataValid);

  p_reset_state_r10: assert property (@(posedge clk)
    rst |=> cursorNow == '0 && !phaseNow && !dataValid && !overrun && !cmdFwdValid);

  p_cmd_drops_req_r11: assert property (@(posedge clk) disable iff (rst)
    cmdValid |-> !bufRdEn ##1 !dataValid);

endmodule

bind pbuf_read_cursor pbuf_read_cursor_chk #(
  .ADDR_W    (ADDR_W),
  .HALF_OFF  (HALF_OFF),
  .SPARE_BASE(SPARE_BASE),
  .LAST_ADDR (LAST_ADDR)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmdValid   (cmdValid),
  .cmdCode    (cmdCode),
  .nextReq    (nextReq),
  .wideMode   (wideMode),
  .cmdFwdValid(cmdFwdValid),
  .cmdFwdCode (cmdFwdCode),
  .bufRdEn    (bufRdEn),
  .bufRdAddr  (bufRdAddr),
  .dataValid  (dataValid),
  .dataOut    (dataOut),
  .overrun    (overrun),
  .cursorNow  (cursorNow),
  .phaseNow   (phaseNow)
);

// File: tb/tb_pbuf_read_cursor.sv
module tb_pbuf_read_cursor;

  localparam int ADDR_W = 9;   // matches the default parameters
  localparam int HALF   = 128;
  localparam int SPARE  = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmdValid = 1'b0;
  logic [7:0] cmdCode = '0;
  logic nextReq = 1'b0;
  logic wideMode = 1'b0;
  logic [15:0] bufRdData = '0;
  logic cmdFwdValid, bufRdEn, dataValid, overrun;
  logic [7:0] cmdFwdCode;
  logic [ADDR_W-1:0] bufRdAddr;
  logic [15:0] dataOut;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  pbuf_read_cursor dut (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .nextReq(nextReq), .wideMode(wideMode), .bufRdData(bufRdData),
    .cmdFwdValid(cmdFwdValid), .cmdFwdCode(cmdFwdCode), .bufRdEn(bufRdEn),
    .bufRdAddr(bufRdAddr), .dataValid(dataValid), .dataOut(dataOut),
    .overrun(overrun)
  );

  function automatic logic [15:0] memVal(input int a);
    return {8'(a) + 8'h40, 8'(a) ^ 8'h5A};
  endfunction

  always_ff @(posedge clk) if (bufRdEn) bufRdData <= memVal(int'(bufRdAddr));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // lane: 0 low byte, 1 high byte, 2 halfword, 3 overrun
  task automatic doReq(input string req, input logic wide, input int addr, input int lane);
    logic [15:0] w;
    @(negedge clk);
    nextReq = 1'b1; wideMode = wide;
    #1;
    chk({req, " rdEn"}, 32'(bufRdEn), (lane == 3) ? 0 : 1);
    if (lane != 3) chk({req, " addr"}, 32'(bufRdAddr), 32'(addr));
    @(negedge clk);
    nextReq = 1'b0;
    w = memVal(addr);
    chk({req, " valid"}, 32'(dataValid), 1);
    chk({req, " ovr"}, 32'(overrun), (lane == 3) ? 1 : 0);
    case (lane)
      0: chk({req, " data"}, 32'(dataOut), 32'({8'h0, w[7:0]}));
      1: chk({req, " data"}, 32'(dataOut), 32'({8'h0, w[15:8]}));
      2: chk({req, " data"}, 32'(dataOut), 32'(w));
      default: chk({req, " data"}, 32'(dataOut), 0);
    endcase
  endtask

  task automatic doCmd(input string req, input logic [7:0] code);
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = code;
    @(negedge clk);
    cmdValid = 1'b0;
    chk({req, " fwdValid"}, 32'(cmdFwdValid), 1);
    chk({req, " fwdCode"}, 32'(cmdFwdCode),
        (code == 8'h50 || code == 8'h01) ? 0 : 32'(code));
  endtask

  typedef struct packed {
    logic        isCmd;
    logic [7:0]  code;
    logic        wide;
    logic [1:0]  lane;
    logic [15:0] addr;
    logic [3:0]  reqNo;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h00, 1'b0, 2'd0, 16'd0,   4'd3},  // R3
    '{1'b0, 8'h00, 1'b0, 2'd0, 16'd0,   4'd6},  // R6 low
    '{1'b0, 8'h00, 1'b0, 2'd1, 16'd0,   4'd6},  // R6 high
    '{1'b0, 8'h00, 1'b0, 2'd0, 16'd1,   4'd6},  // R6 advanced
    '{1'b1, 8'h30, 1'b0, 2'd0, 16'd0,   4'd4},  // R4 other code
    '{1'b0, 8'h00, 1'b0, 2'd0, 16'd0,   4'd5},  // R5 phase low again
    '{1'b1, 8'h01, 1'b0, 2'd0, 16'd0,   4'd2},  // R2
    '{1'b0, 8'h00, 1'b1, 2'd2, 16'd128, 4'd7},  // R7
    '{1'b0, 8'h00, 1'b1, 2'd2, 16'd129, 4'd7},  // R7
    '{1'b0, 8'h00, 1'b0, 2'd0, 16'd130, 4'd6},  // R6
    '{1'b1, 8'h50, 1'b0, 2'd0, 16'd0,   4'd1},  // R1
    '{1'b0, 8'h00, 1'b0, 2'd0, 16'd256, 4'd1},  // R1 spare start
    '{1'b0, 8'h00, 1'b0, 2'd1, 16'd256, 4'd6},  // R6
    '{1'b0, 8'h00, 1'b1, 2'd2, 16'd257, 4'd7}   // R7
  };

  bit finished = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 valid", 32'(dataValid), 0);
    chk("R10 ovr", 32'(overrun), 0);
    chk("R10 fwd", 32'(cmdFwdValid), 0);
    rst = 1'b0;
    doReq("R10 cursor at start", 1'b0, 0, 0);

    foreach (VECS[i]) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].reqNo, i);
      if (VECS[i].isCmd) doCmd(tag, VECS[i].code);
      else doReq(tag, VECS[i].wide, int'(VECS[i].addr), int'(VECS[i].lane));
    end

    // R8 overrun at end of spare area
    doCmd("R1 spare", 8'h50);
    for (int a = SPARE; a < SPARE + 7; a++) doReq("R7 walk", 1'b1, a, 2);
    doReq("R6 last low", 1'b0, SPARE + 7, 0);
    doReq("R6 last high", 1'b0, SPARE + 7, 1);
    doReq("R8 overrun byte", 1'b0, 0, 3);
    doReq("R8 overrun wide", 1'b1, 0, 3);
    doCmd("R3 recover", 8'h90);
    doReq("R3 main start", 1'b1, 0, 2);

    // R11 command and request together
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = 8'h01; nextReq = 1'b1; wideMode = 1'b1;
    #1 chk("R11 no read", 32'(bufRdEn), 0);
    @(negedge clk);
    cmdValid = 1'b0; nextReq = 1'b0;
    chk("R11 no data", 32'(dataValid), 0);
    doReq("R11 R2 applied", 1'b1, HALF, 2);

    // R10 reset mid byte sequence
    doReq("R6 pre-reset low", 1'b0, HALF + 1, 0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R10 valid after", 32'(dataValid), 0);
    doReq("R10 restart low", 1'b0, 0, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule